// File: doc/BRIEF.md
# Shift-Add Constant Multiplier with a Shared Digit Pattern

This block multiplies a signed integer sample by a constant fixed at elaboration time. It uses no multiplier. The constant is recoded into canonic signed digits, so no two neighbouring digits are both nonzero. Each nonzero digit then stands for one shifted copy of the input, added or subtracted. Where two digits of the same sign sit two places apart, the pair is covered by one shared term `t = x + 4x`, which is built once and then shifted into place. For 85 this takes two adders instead of three.

An optional arithmetic right shift by `CWL` turns the integer constant into a fractional coefficient `C / 2^CWL`, with the low bits truncated. Samples enter and leave on valid/ready streams, with one register stage between them.

Back-pressure rules:
- An input is taken on a rising edge where `in_valid` and `in_ready` are both high.
- A result leaves on a rising edge where `out_valid` and `out_ready` are both high.
- While a result is held and not taken, the block refuses new input, and the held result does not change.

Top module: `cmul_shared_const`

## Requirements
- R1: With `CWL` = 0, `out_data` equals `in_data` × `COEF` as a signed two's-complement value, for every input of width `IN_W` (for example 85 and 15).
- R2: With `CWL` > 0, `out_data` equals (`in_data` × `COEF`) shifted right arithmetically by `CWL` bits, with the bits shifted out dropped. This rounds toward minus infinity.
- R3: A negative `COEF` gives the correctly signed product for inputs of either sign.
- R4: With `COEF` = 0, every accepted sample produces a result equal to zero.
- R5: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is low; with nothing held, `in_ready` is high.
- R6: A sample taken on a rising edge appears on `out_data`, with `out_valid` high, right after that same edge (latency of one cycle).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value on the next cycle. An `in_valid` offered during that time has no effect on the output.
- R8: `in_ready` is low exactly when a result is held and `out_ready` is low; otherwise it is high.
- R9: When the held result is taken and no new sample is taken on the same edge, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | Downstream takes the held result |
| out_data | output | IN_W + bitlen(abs(COEF)) + 1 | Signed scaled product |

## Verification
The assertions assume the following:
- The inputs carry known values at each rising edge after reset.
- The true product `in_data` × `COEF` fits in 64 bits, so the wide reference product in the checker is exact.
- `CWL` stays below 64.

The bench keeps within these limits as follows:
- It uses 6-bit samples and constants of at most 85 in magnitude.
- It changes every input only at falling edges, so no input moves near a sampling edge.
- Several lanes with different constants and shifts receive the same full sweep of the input range.
- It runs the sweep once with a free output and once with a pseudo-random `out_ready` pattern, and adds a directed stall.

// File: rtl/cmul_pkg.sv
`timescale 1ns/1ps
package cmul_pkg;

  localparam int DIG_MAX = 40;
  typedef logic [DIG_MAX-1:0] digits_t;

  function automatic longint magnitude(input longint c);
    return (c < 0) ? -c : c;
  endfunction

  // number of bits in v (at least 1)
  function automatic int bit_len(input longint v);
    int n = 0;
    for (int i = 0; i < 63; i++) begin
      if ((v >> i) != 0) n = i + 1;
    end
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int prod_width(input int in_w, input longint c);
    return in_w + bit_len(magnitude(c)) + 1;
  endfunction

  // Signed-digit recoding: one mask for +1 digits, one for -1 digits
  function automatic digits_t csd_mask(input longint mag, input bit want_minus);
    longint  rem = mag;
    digits_t res = '0;
    for (int i = 0; i < DIG_MAX; i++) begin
      if ((rem & 64'sd1) != 0) begin
        if ((rem & 64'sd3) == 64'sd1) begin
          if (!want_minus) res[i] = 1'b1;
          rem = rem - 1;
        end else begin
          if (want_minus) res[i] = 1'b1;
          rem = rem + 1;
        end
      end
      rem = rem >>> 1;
    end
    return res;
  endfunction

  // Lowest digit of each pair (k, k+2) covered by the shared term x + 4x
  function automatic digits_t pair_bases(input digits_t m);
    digits_t used = '0;
    digits_t res  = '0;
    for (int k = 0; k < DIG_MAX - 2; k++) begin
      if (m[k] && m[k+2] && !used[k] && !used[k+2]) begin
        res[k]    = 1'b1;
        used[k]   = 1'b1;
        used[k+2] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic digits_t lone_digits(input digits_t m, input digits_t p);
    return m & ~(p | (p << 2));
  endfunction

endpackage

// File: rtl/cmul_shift_add.sv
`timescale 1ns/1ps
module cmul_shift_add #(
  parameter int IN_W   = 8,
  parameter int COEF   = 85,
  parameter int PROD_W = 16
) (
  input  logic signed [IN_W-1:0]   x,
  output logic signed [PROD_W-1:0] p
);
  import cmul_pkg::*;

  localparam longint  MAG    = magnitude(longint'(COEF));
  localparam int      NDIG   = bit_len(MAG) + 1;
  localparam digits_t RAW_P  = csd_mask(MAG, 1'b0);
  localparam digits_t RAW_N  = csd_mask(MAG, 1'b1);
  localparam digits_t PLUS   = (COEF < 0) ? RAW_N : RAW_P;
  localparam digits_t MINUS  = (COEF < 0) ? RAW_P : RAW_N;
  localparam digits_t PAIR_P = pair_bases(PLUS);
  localparam digits_t PAIR_N = pair_bases(MINUS);
  localparam digits_t LONE_P = lone_digits(PLUS, PAIR_P);
  localparam digits_t LONE_N = lone_digits(MINUS, PAIR_N);
  localparam bit      USE_T  = |(PAIR_P | PAIR_N);

  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] t_sh;
  logic signed [PROD_W-1:0] pos_t [NDIG];
  logic signed [PROD_W-1:0] neg_t [NDIG];

  assign x_ext = PROD_W'(x);

  // shared subexpression, built once
  generate
    if (USE_T) begin : g_shared
      assign t_sh = x_ext + (x_ext <<< 2);
    end else begin : g_noshare
      assign t_sh = '0;
    end
  endgenerate

  generate
    for (genvar k = 0; k < NDIG; k++) begin : g_digit
      if (PAIR_P[k]) begin : g_pp
        assign pos_t[k] = t_sh <<< k;
      end else if (LONE_P[k]) begin : g_lp
        assign pos_t[k] = x_ext <<< k;
      end else begin : g_zp
        assign pos_t[k] = '0;
      end

      if (PAIR_N[k]) begin : g_pn
        assign neg_t[k] = t_sh <<< k;
      end else if (LONE_N[k]) begin : g_ln
        assign neg_t[k] = x_ext <<< k;
      end else begin : g_zn
        assign neg_t[k] = '0;
      end
    end
  endgenerate

  always_comb begin
    logic signed [PROD_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NDIG; k++) begin
      acc = acc + pos_t[k] - neg_t[k];
    end
    p = acc;
  end

endmodule

// File: rtl/cmul_scale.sv
`timescale 1ns/1ps
module cmul_scale #(
  parameter int W   = 16,
  parameter int CWL = 0
) (
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  generate
    if (CWL == 0) begin : g_pass
      assign dout = din;
    end else begin : g_shift
      assign dout = din >>> CWL;
    end
  endgenerate
endmodule

// File: rtl/cmul_pipe_reg.sv
`timescale 1ns/1ps
module cmul_pipe_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign s_ready = !vld_q || m_ready;
  assign m_valid = vld_q;
  assign m_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (s_ready) begin
      vld_q <= s_valid;
      if (s_valid) dat_q <= s_data;
    end
  end
endmodule

// File: rtl/cmul_shared_const.sv
`timescale 1ns/1ps
module cmul_shared_const #(
  parameter int IN_W = 8,
  parameter int COEF = 85,
  parameter int CWL  = 0,
  localparam int PROD_W = cmul_pkg::prod_width(IN_W, longint'(COEF))
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [IN_W-1:0]   in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [PROD_W-1:0] out_data
);
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;
  logic        [PROD_W-1:0] held;

  cmul_shift_add #(.IN_W(IN_W), .COEF(COEF), .PROD_W(PROD_W)) u_tree (
    .x (in_data),
    .p (prod)
  );

  cmul_scale #(.W(PROD_W), .CWL(CWL)) u_scale (
    .din  (prod),
    .dout (scaled)
  );

  cmul_pipe_reg #(.W(PROD_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (scaled),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (held)
  );

  assign out_data = signed'(held);
endmodule

// File: rtl/cmul_shared_const_chk.sv
`timescale 1ns/1ps
module cmul_shared_const_chk #(
  parameter int IN_W   = 8,
  parameter int COEF   = 85,
  parameter int CWL    = 0,
  parameter int PROD_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [IN_W-1:0]   in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [PROD_W-1:0] out_data
);
  longint ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 0;
    else if (in_valid && in_ready)
      ref_q <= (longint'(in_data) * longint'(COEF)) >>> CWL;
  end

  // R1 (also covers R2, R3, R4): result matches a wide multiply
  p_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_data) == ref_q));

  p_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind cmul_shared_const cmul_shared_const_chk #(
  .IN_W(IN_W), .COEF(COEF), .CWL(CWL), .PROD_W(PROD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/cmul_shared_const_tb_top.sv
`timescale 1ns/1ps
module cmul_shared_const_tb_top;
  localparam int IN_W = 6;
  localparam int NL   = 6;
  localparam int CS [NL] = '{85, 15, -85, 0, 85, -13};
  localparam int CW [NL] = '{0, 0, 0, 0, 4, 2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;

  logic [NL-1:0] ov_a;
  logic [NL-1:0] ir_a;
  longint od_a [NL];

  longint exp_q [NL][$];
  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  function automatic string tag_of(input int g);
    case (g)
      2:       return "R3";
      3:       return "R4";
      4, 5:    return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  generate
    for (genvar g = 0; g < NL; g++) begin : lane
      localparam int PW = cmul_pkg::prod_width(IN_W, longint'(CS[g]));
      logic signed [PW-1:0] od;
      logic ov;
      logic ir;

      cmul_shared_const #(.IN_W(IN_W), .COEF(CS[g]), .CWL(CW[g])) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(ir), .in_data(in_data),
        .out_valid(ov), .out_ready(out_ready), .out_data(od)
      );

      assign ov_a[g] = ov;
      assign ir_a[g] = ir;
      assign od_a[g] = longint'(od);

      // monitor: compare each result in the cycle it is handed over
      always @(negedge clk) begin
        #2;
        if (rst_n && ov && out_ready) begin
          if (exp_q[g].size() == 0) begin
            check(1'b0, tag_of(g), longint'(od), 0);
          end else begin
            longint e;
            e = exp_q[g].pop_front();
            check(longint'(od) == e, tag_of(g), longint'(od), e);
          end
        end
      end
    end
  endgenerate

  function automatic longint model(input logic signed [IN_W-1:0] x, input int g);
    longint pr;
    pr = longint'(x) * longint'(CS[g]);
    return pr >>> CW[g];
  endfunction

  task automatic push_all(input logic signed [IN_W-1:0] x);
    for (int g = 0; g < NL; g++) exp_q[g].push_back(model(x, g));
  endtask

  // driver: offers x until it is taken, out_ready optionally random
  task automatic send(input logic signed [IN_W-1:0] x, input bit bp);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = bp ? lfsr[0] : 1'b1;
      in_valid = 1'b1;
      in_data = x;
      #1;
      if (ir_a[0]) begin
        push_all(x);
        done = 1'b1;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: reset state
    for (int g = 0; g < NL; g++) begin
      check(ov_a[g] == 1'b0, "R5", longint'(ov_a[g]), 0);
      check(ir_a[g] == 1'b1, "R5", longint'(ir_a[g]), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(ov_a[0] == 1'b0, "R5", longint'(ov_a[0]), 0);

    // R6: latency of one cycle; R7/R8: stall holds data and blocks input
    in_valid = 1'b1; in_data = 6'sd5; out_ready = 1'b0;
    push_all(6'sd5);
    @(negedge clk);
    check(ov_a[0] == 1'b1, "R6", longint'(ov_a[0]), 1);
    check(od_a[0] == 425, "R6", od_a[0], 425);
    in_data = -6'sd3;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check(ov_a[0] == 1'b1, "R7", longint'(ov_a[0]), 1);
      check(od_a[0] == 425, "R7", od_a[0], 425);
      check(od_a[2] == -425, "R7", od_a[2], -425);
      check(ir_a[0] == 1'b0, "R8", longint'(ir_a[0]), 0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    #1;
    check(ir_a[0] == 1'b1, "R8", longint'(ir_a[0]), 1);
    @(negedge clk);
    check(ov_a[0] == 1'b0, "R9", longint'(ov_a[0]), 0);

    // full sweep, free output, then with back-pressure
    for (int v = -(1 << (IN_W-1)); v < (1 << (IN_W-1)); v++) send(IN_W'(v), 1'b0);
    for (int v = (1 << (IN_W-1)) - 1; v >= -(1 << (IN_W-1)); v--) send(IN_W'(v), 1'b1);

    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 20; i++) @(negedge clk);
    for (int g = 0; g < NL; g++)
      check(exp_q[g].size() == 0, tag_of(g), longint'(exp_q[g].size()), 0);
    check(ov_a[0] == 1'b0, "R9", longint'(ov_a[0]), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule